// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block moves data between two tri-state buses, called A and B, in both directions. Each direction has its own storage stage and its own four controls: an active-low output enable, a latch enable, a capture strobe and an active-low strobe enable. With the latch enable high, the storage stage passes its source bus straight through. With the latch enable low, it keeps its content, and it takes a new word only on a falling edge of its strobe while the strobe enable is asserted. The stored word drives the opposite bus whenever that direction's output enable is low. Otherwise the block leaves that bus in high impedance.

The design targets an FPGA fabric and runs on a single system clock. The strobes are sampled on that clock and their falling edges are detected there. The storage stages, the edge detectors and the drive enables are all flip-flops with a synchronous active-high reset. A change of a control or of a source bus therefore appears at the destination bus one system clock later. The two directions are identical and share no control. The data width is a parameter with a default of 18.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: A synchronous reset clears both storage stages to zero and releases both buses to high impedance. Once the output enables go low after reset, both buses read all zeros.
- R2: While the A-to-B latch enable is high, the A-to-B stage loads the word on the A bus at every system clock edge, so B follows A one cycle later.
- R3: While the latch enable is low and the strobe holds steady at either level, the stored word does not change, even when the source bus changes.
- R4: While the latch enable is low and the strobe enable is low, a high-to-low change of the strobe makes the stage load the source word. The load happens at the first system clock edge that sees the strobe low after it was high.
- R5: A falling strobe is ignored while the active-low strobe enable is high.
- R6: When the output enable of a direction is low, its destination bus is driven from its stored word one cycle later. When the output enable is high, that bus is high impedance one cycle later.
- R7: The B-to-A direction behaves the same way, using its own four controls. The A-to-B controls have no effect on what the A bus shows.
- R8: When the latch enable goes from high to low, the stage keeps the last word it passed through until the next enabled falling strobe.
- R9: A rising strobe edge loads nothing.
- R10: When both output enables are low, each bus is driven from the stored word of the direction that targets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_io | inout | W | A bus (source for A-to-B, destination for B-to-A) |
| b_io | inout | W | B bus (source for B-to-A, destination for A-to-B) |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, active high |
| ab_stb | input | 1 | A-to-B capture strobe (falling edge loads) |
| ab_ce_n | input | 1 | A-to-B strobe enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, active high |
| ba_stb | input | 1 | B-to-A capture strobe (falling edge loads) |
| ba_ce_n | input | 1 | B-to-A strobe enable, active low |

## Verification
The assertions assume that the controls and the source buses change in step with the system clock. They also assume that no external agent drives a bus while the block drives it, because the drive checks compare the bus wires with the stored word. The bench changes every input only on the inactive clock edge. It releases its own bus driver before it lowers the output enable that targets that bus. Each stored word is loaded only from a bus that is actually being driven, so no stage ever holds high impedance.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic oe_n;
    logic le;
    logic stb;
    logic ce_n;
  } xcvr_ctl_t;
endpackage

// File: rtl/xcvr_fall_det.sv
module xcvr_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  output logic stb_q,
  output logic fall
);
  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= stb;
  end

  assign fall = stb_q & ~stb;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      d,
  input  xcvr_pkg::xcvr_ctl_t ctl,
  input  logic              fall,
  output logic [W-1:0]      q
);
  logic load;

  // transparent path takes priority; otherwise only an enabled falling strobe loads
  assign load = ctl.le | (fall & ~ctl.ce_n);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive (
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  output logic drive
);
  always_ff @(posedge clk) begin
    if (rst) drive <= 1'b0;
    else     drive <= ~oe_n;
  end
endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  inout  wire  [W-1:0] a_io,
  inout  wire  [W-1:0] b_io,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_stb,
  input  logic         ab_ce_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_stb,
  input  logic         ba_ce_n
);
  import xcvr_pkg::*;

  localparam int NDIR = 2;

  xcvr_ctl_t        ctl   [NDIR];
  logic [W-1:0]     src   [NDIR];
  logic [W-1:0]     q     [NDIR];
  logic             stb_q [NDIR];
  logic             fall  [NDIR];
  logic             drive [NDIR];

  assign ctl[0] = '{oe_n: ab_oe_n, le: ab_le, stb: ab_stb, ce_n: ab_ce_n};
  assign ctl[1] = '{oe_n: ba_oe_n, le: ba_le, stb: ba_stb, ce_n: ba_ce_n};
  assign src[0] = a_io;
  assign src[1] = b_io;

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    xcvr_fall_det u_fall (
      .clk   (clk),
      .rst   (rst),
      .stb   (ctl[g].stb),
      .stb_q (stb_q[g]),
      .fall  (fall[g])
    );

    xcvr_store #(.W(W)) u_store (
      .clk  (clk),
      .rst  (rst),
      .d    (src[g]),
      .ctl  (ctl[g]),
      .fall (fall[g]),
      .q    (q[g])
    );

    xcvr_drive u_drive (
      .clk   (clk),
      .rst   (rst),
      .oe_n  (ctl[g].oe_n),
      .drive (drive[g])
    );
  end

  // named views for the checker
  logic [W-1:0] ab_q, ba_q;
  logic         ab_stb_q, ba_stb_q;
  assign ab_q     = q[0];
  assign ba_q     = q[1];
  assign ab_stb_q = stb_q[0];
  assign ba_stb_q = stb_q[1];

  assign b_io = drive[0] ? q[0] : {W{1'bz}};
  assign a_io = drive[1] ? q[1] : {W{1'bz}};
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_io,
  input logic [W-1:0] b_io,
  input logic         ab_oe_n,
  input logic         ab_le,
  input logic         ab_stb,
  input logic         ab_ce_n,
  input logic         ba_oe_n,
  input logic         ba_le,
  input logic         ba_stb,
  input logic         ba_ce_n,
  input logic [W-1:0] ab_q,
  input logic [W-1:0] ba_q,
  input logic         ab_stb_q,
  input logic         ba_stb_q
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ab_q === '0 && ba_q === '0));

  assert_transparent_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ab_le)) |-> (ab_q === $past(a_io)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ab_le) &&
     !($past(ab_stb_q) && !$past(ab_stb) && !$past(ab_ce_n))) |-> (ab_q === $past(ab_q)));

  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ab_le) && $past(ab_stb_q) && !$past(ab_stb) && !$past(ab_ce_n))
      |-> (ab_q === $past(a_io)));

  assert_drive_b_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ab_oe_n)) |-> (b_io === ab_q));

  assert_drive_a_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ba_oe_n)) |-> (a_io === ba_q));

  assert_hold_ba_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ba_le) &&
     !($past(ba_stb_q) && !$past(ba_stb) && !$past(ba_ce_n))) |-> (ba_q === $past(ba_q)));
endmodule

bind bidir_reg_xcvr xcvr_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .a_io     (a_io),
  .b_io     (b_io),
  .ab_oe_n  (ab_oe_n),
  .ab_le    (ab_le),
  .ab_stb   (ab_stb),
  .ab_ce_n  (ab_ce_n),
  .ba_oe_n  (ba_oe_n),
  .ba_le    (ba_le),
  .ba_stb   (ba_stb),
  .ba_ce_n  (ba_ce_n),
  .ab_q     (ab_q),
  .ba_q     (ba_q),
  .ab_stb_q (ab_stb_q),
  .ba_stb_q (ba_stb_q)
);

// File: tb/bidir_reg_xcvr_bench.sv
`timescale 1ns/1ps
module bidir_reg_xcvr_bench;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ab_oe_n = 1'b1, ab_le = 1'b0, ab_stb = 1'b0, ab_ce_n = 1'b1;
  logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_stb = 1'b0, ba_ce_n = 1'b1;
  logic         a_en = 1'b0, b_en = 1'b0;
  logic [W-1:0] a_drv = '0, b_drv = '0;
  wire  [W-1:0] a_io, b_io;

  int checks = 0;
  int errors = 0;

  assign a_io = a_en ? a_drv : {W{1'bz}};
  assign b_io = b_en ? b_drv : {W{1'bz}};

  always #4 clk = ~clk;

  bidir_reg_xcvr #(.W(W)) u_bidir_reg_xcvr (
    .clk(clk), .rst(rst), .a_io(a_io), .b_io(b_io),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_stb(ab_stb), .ab_ce_n(ab_ce_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_stb(ba_stb), .ba_ce_n(ba_ce_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(1);
    check("R1 b hi-z", b_io, {W{1'bz}});
    check("R1 a hi-z", a_io, {W{1'bz}});
    ab_oe_n = 1'b0; ba_oe_n = 1'b0;
    step(1);
    check("R1 b zero", b_io, '0);
    check("R1 a zero", a_io, '0);
    ab_oe_n = 1'b1; ba_oe_n = 1'b1;
    step(1);
  endtask

  task automatic t_transparent;
    a_en = 1'b1; a_drv = 18'h2A5A5;
    ab_le = 1'b1; ab_oe_n = 1'b0;
    step(1);
    check("R2 follow 1", b_io, 18'h2A5A5);
    a_drv = 18'h15A5A;
    step(1);
    check("R2 follow 2", b_io, 18'h15A5A);
  endtask

  task automatic t_retain;
    ab_le = 1'b0; a_drv = 18'h3FFFF;
    step(2);
    check("R8 retained", b_io, 18'h15A5A);
  endtask

  task automatic t_hold_and_gate;
    ab_stb = 1'b1; a_drv = 18'h01234;
    step(3);
    check("R3 strobe high steady", b_io, 18'h15A5A);
    ab_stb = 1'b0;
    step(1);
    check("R5 gated fall ignored", b_io, 18'h15A5A);
    ab_ce_n = 1'b0; a_drv = 18'h0ABCD;
    step(3);
    check("R3 strobe low steady", b_io, 18'h15A5A);
  endtask

  task automatic t_rise_and_capture;
    a_drv = 18'h11111; ab_stb = 1'b1;
    step(1);
    check("R9 rising ignored", b_io, 18'h15A5A);
    a_drv = 18'h2C3D4;
    step(1);
    ab_stb = 1'b0;
    step(1);
    check("R4 fall captures", b_io, 18'h2C3D4);
    a_drv = 18'h00007;
    step(2);
    check("R3 after capture", b_io, 18'h2C3D4);
  endtask

  task automatic t_oe;
    ab_oe_n = 1'b1;
    step(1);
    check("R6 disabled hi-z", b_io, {W{1'bz}});
    ab_oe_n = 1'b0;
    step(1);
    check("R6 re-enabled", b_io, 18'h2C3D4);
    ab_oe_n = 1'b1; ab_ce_n = 1'b1;
    a_en = 1'b0;
    step(1);
  endtask

  task automatic t_mirror;
    b_en = 1'b1; b_drv = 18'h13579;
    ba_le = 1'b1; ba_oe_n = 1'b0;
    step(1);
    check("R7 b-to-a transparent", a_io, 18'h13579);
    ba_le = 1'b0;
    step(1);
    b_drv = 18'h24680;
    ab_le = 1'b1; ab_ce_n = 1'b0; ab_stb = 1'b1;
    step(1);
    ab_stb = 1'b0;
    step(2);
    check("R7 a-to-b controls no effect", a_io, 18'h13579);
    ab_le = 1'b0; ab_ce_n = 1'b1;
    ba_ce_n = 1'b0; ba_stb = 1'b1;
    step(1);
    ba_stb = 1'b0;
    step(1);
    check("R7 b-to-a capture", a_io, 18'h24680);
    ba_ce_n = 1'b1; ba_oe_n = 1'b1; b_en = 1'b0;
    step(1);
  endtask

  task automatic t_both;
    a_en = 1'b1; a_drv = 18'h0F0F0;
    ab_le = 1'b1;
    step(1);
    ab_le = 1'b0;
    step(1);
    a_en = 1'b0;
    b_en = 1'b1; b_drv = 18'h30303;
    ba_le = 1'b1;
    step(1);
    ba_le = 1'b0;
    step(1);
    b_en = 1'b0;
    ab_oe_n = 1'b0; ba_oe_n = 1'b0;
    step(1);
    check("R10 b from a-to-b store", b_io, 18'h0F0F0);
    check("R10 a from b-to-a store", a_io, 18'h30303);
    ab_oe_n = 1'b1; ba_oe_n = 1'b1;
    step(1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_transparent();
        t_retain();
        t_hold_and_gate();
        t_rise_and_capture();
        t_oe();
        t_mirror();
        t_both();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule